// File: doc/BRIEF.md
# Serial Flash Master Controller

The block is a register-mapped serial master that runs one transfer at a time against a serial flash or a slave peripheral. Software fills in an opcode, an address, an optional outgoing data word and a data length, then writes a start bit. The controller lowers chip select and clocks out the opcode and then the address, which takes three or four bytes as a configuration bit selects. For reads it may add a dummy pre-data byte, and it then moves up to four data bytes out or in. Every byte goes most significant bit first. Received bytes land in a receive register that software reads once the busy flag drops.

Two configuration bits tune the receive path. One moves the receive sample point from the rising clock edge to the falling edge that follows it. The other turns off the pre-data byte for flash devices. A start request made while a transfer is running is dropped, and the running transfer is not affected.

Top module: `spi_flash_master`

## Requirements
- R1: After reset the status and configuration registers read 0, chip select is high, and the serial clock and MOSI are low.
- R2: Offset 0x00 bit 0 reads 1 while a transfer runs and 0 otherwise. Offset 0x10 holds writable bits 12, 11 and 10. Every other bit of both registers reads 0.
- R3: Writing offset 0x1C with bit 0 set starts a transfer when idle. While busy, such a write is ignored: the running frame is unchanged and no extra frame follows.
- R4: A frame is, in this order, the opcode byte, the address bytes, the optional pre-data byte and then the data bytes. Each byte is sent MSB first, and the address goes most significant byte first.
- R5: Configuration bit 12 = 0 sends address bits 23:0 as three bytes. Bit 12 = 1 sends all 32 address bits as four bytes.
- R6: With configuration bit 11 = 0, a read that has at least one data byte gets one zero pre-data byte between the address and the data. With bit 11 = 1, or on a transfer without data, there is none.
- R7: Offset 0x04 holds the opcode in bits 7:0, the data length in bits 10:8 (values above 4 act as 4) and the direction in bit 16 (1 = read). A write sends the low length×8 bits of offset 0x0C, MSB first. During read data, MOSI is 0.
- R8: Read bytes are collected right-aligned at offset 0x18, with the earliest byte most significant and all other bits 0. The register is cleared at each start, so a write transfer leaves it 0.
- R9: Mode 0 is used. The clock idles low and pulses only while chip select is low. MOSI changes only at the start of a frame or when the clock falls. MISO is sampled on the rising edge when configuration bit 10 = 0.
- R10: With configuration bit 10 = 1, MISO is sampled on the falling edge that follows each rising edge.
- R11: A clock half-period is N+1 system cycles, where N is the value at offset 0x14. Chip select falls one half-period before the first rising edge and rises one half-period after the last falling edge. Busy clears in the same cycle that chip select rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 8 | Register byte offset |
| we_i | input | 1 | Register write strobe |
| wdata_i | input | 32 | Register write data |
| rdata_o | output | 32 | Register read data for addr_i |
| sclk_o | output | 1 | Serial clock |
| cs_n_o | output | 1 | Chip select, active low |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |

## Verification
A flash model counts the clocked bytes, records MOSI and plays back a known byte stream. The bench can then tell a frame that drops the fourth address byte, or loses or wrongly gains the pre-data byte, from a correct one. The stream would also show up a receive register filled from the wrong byte positions. A second model mode presents each bit only after the rising edge, so a design that ignores the capture-delay bit returns data that is one bit stale. A start that is rewritten mid-frame with a new opcode would show as a changed frame or an extra frame. Divider values above zero expose chip-select setup and hold off by a cycle, and an oversized length field exposes a missing clamp.

// File: rtl/spi_fm_pkg.sv
package spi_fm_pkg;
  localparam logic [7:0] OFS_STAT = 8'h00;
  localparam logic [7:0] OFS_CMD  = 8'h04;
  localparam logic [7:0] OFS_ADDR = 8'h08;
  localparam logic [7:0] OFS_TXD  = 8'h0C;
  localparam logic [7:0] OFS_CFG  = 8'h10;
  localparam logic [7:0] OFS_DIV  = 8'h14;
  localparam logic [7:0] OFS_RXD  = 8'h18;
  localparam logic [7:0] OFS_GO   = 8'h1C;

  localparam int CFG_ADDR4  = 12;
  localparam int CFG_ENVDIS = 11;
  localparam int CFG_CAPDLY = 10;

  typedef enum logic [1:0] {ST_IDLE, ST_LEAD, ST_SHIFT, ST_TAIL} eng_st_e;

  typedef struct packed {
    logic addr4;
    logic env_dis;
    logic cap_dly;
  } cfg_t;
endpackage

// File: rtl/spi_fm_regs.sv
module spi_fm_regs
  import spi_fm_pkg::*;
#(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [7:0]       addr_i,
  input  logic             we_i,
  input  logic [31:0]      wdata_i,
  output logic [31:0]      rdata_o,
  input  logic             busy_i,
  input  logic [31:0]      rx_i,
  output logic [7:0]       op_o,
  output logic [2:0]       len_o,
  output logic             rd_o,
  output logic [31:0]      addr_o,
  output logic [31:0]      txd_o,
  output cfg_t             cfg_o,
  output logic [DIV_W-1:0] div_o,
  output logic             go_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_o   <= '0;
      len_o  <= '0;
      rd_o   <= 1'b0;
      addr_o <= '0;
      txd_o  <= '0;
      cfg_o  <= '0;
      div_o  <= '0;
    end else if (we_i) begin
      case (addr_i)
        OFS_CMD: begin
          op_o  <= wdata_i[7:0];
          len_o <= wdata_i[10:8];
          rd_o  <= wdata_i[16];
        end
        OFS_ADDR: addr_o <= wdata_i;
        OFS_TXD:  txd_o  <= wdata_i;
        OFS_CFG:  cfg_o  <= '{addr4:   wdata_i[CFG_ADDR4],
                               env_dis: wdata_i[CFG_ENVDIS],
                               cap_dly: wdata_i[CFG_CAPDLY]};
        OFS_DIV:  div_o  <= wdata_i[DIV_W-1:0];
        default: ;
      endcase
    end
  end

  assign go_o = we_i && (addr_i == OFS_GO) && wdata_i[0];

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      OFS_STAT: rdata_o[0] = busy_i;
      OFS_CMD:  rdata_o = {15'd0, rd_o, 5'd0, len_o, op_o};
      OFS_ADDR: rdata_o = addr_o;
      OFS_TXD:  rdata_o = txd_o;
      OFS_CFG: begin
        rdata_o[CFG_ADDR4]  = cfg_o.addr4;
        rdata_o[CFG_ENVDIS] = cfg_o.env_dis;
        rdata_o[CFG_CAPDLY] = cfg_o.cap_dly;
      end
      OFS_DIV:  rdata_o = 32'(div_o);
      OFS_RXD:  rdata_o = rx_i;
      default:  rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/spi_fm_clkgen.sv
module spi_fm_clkgen #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             active_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  assign tick_o = active_i && (cnt_q == div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_q <= '0;
    else if (!active_i || tick_o) cnt_q <= '0;
    else                          cnt_q <= cnt_q + DIV_W'(1);
  end
endmodule

// File: rtl/spi_fm_engine.sv
module spi_fm_engine
  import spi_fm_pkg::*;
#(
  parameter int unsigned DATA_BYTES = 4
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        go_i,
  input  logic        tick_i,
  input  logic [7:0]  op_i,
  input  logic [2:0]  len_i,
  input  logic        rd_i,
  input  logic [31:0] addr_i,
  input  logic [31:0] txd_i,
  input  cfg_t        cfg_i,
  input  logic        miso_i,
  output logic        sclk_o,
  output logic        cs_n_o,
  output logic        mosi_o,
  output logic        busy_o,
  output logic        active_o,
  output logic [31:0] rx_o
);
  localparam int FRAME_W = 8 * (1 + 4 + 1 + DATA_BYTES);
  localparam int CNT_W   = $clog2(FRAME_W + 1);

  eng_st_e            st_q;
  logic [FRAME_W-1:0] sh_q, frame_d;
  logic [CNT_W-1:0]   left_q, left_d, dbits_q, dbits_d;
  logic               rd_q, cap_q, in_data;

  // frame image, left-aligned; only frame_d/left_d/dbits_d leave this block
  always_comb begin
    int   pos;
    int   db;
    logic dummy;
    logic [31:0] txm;
    db    = (int'(len_i) > int'(DATA_BYTES)) ? int'(DATA_BYTES) * 8 : int'(len_i) * 8;
    dummy = rd_i && !cfg_i.env_dis && (db != 0);
    txm   = 32'((64'd1 << db) - 64'd1);
    frame_d = '0;
    frame_d[FRAME_W-1 -: 8] = op_i;
    pos = FRAME_W - 8;
    if (cfg_i.addr4) begin
      pos = pos - 32;
      frame_d = frame_d | (FRAME_W'(addr_i) << pos);
    end else begin
      pos = pos - 24;
      frame_d = frame_d | (FRAME_W'(addr_i[23:0]) << pos);
    end
    if (dummy) pos = pos - 8;
    if (!rd_i) frame_d = frame_d | (FRAME_W'(txd_i & txm) << (pos - db));
    left_d  = CNT_W'(FRAME_W - pos + db - 1);
    dbits_d = CNT_W'(db);
  end

  assign in_data  = rd_q && (left_q < dbits_q);
  assign mosi_o   = sh_q[FRAME_W-1];
  assign active_o = (st_q != ST_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      sclk_o  <= 1'b0;
      cs_n_o  <= 1'b1;
      busy_o  <= 1'b0;
      sh_q    <= '0;
      left_q  <= '0;
      dbits_q <= '0;
      rd_q    <= 1'b0;
      cap_q   <= 1'b0;
      rx_o    <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (go_i) begin
          st_q    <= ST_LEAD;
          cs_n_o  <= 1'b0;
          busy_o  <= 1'b1;
          sh_q    <= frame_d;
          left_q  <= left_d;
          dbits_q <= dbits_d;
          rd_q    <= rd_i;
          cap_q   <= cfg_i.cap_dly;
          rx_o    <= '0;
        end
        ST_LEAD: if (tick_i) begin
          sclk_o <= 1'b1;
          st_q   <= ST_SHIFT;
          if (!cap_q && in_data) rx_o <= {rx_o[30:0], miso_i};
        end
        ST_SHIFT: if (tick_i) begin
          if (sclk_o) begin
            sclk_o <= 1'b0;
            if (cap_q && in_data) rx_o <= {rx_o[30:0], miso_i};
            if (left_q == '0) st_q <= ST_TAIL;
            else begin
              left_q <= left_q - CNT_W'(1);
              sh_q   <= sh_q << 1;
            end
          end else begin
            sclk_o <= 1'b1;
            if (!cap_q && in_data) rx_o <= {rx_o[30:0], miso_i};
          end
        end
        ST_TAIL: if (tick_i) begin
          cs_n_o <= 1'b1;
          busy_o <= 1'b0;
          st_q   <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_flash_master.sv
module spi_flash_master
  import spi_fm_pkg::*;
#(
  parameter int unsigned DIV_W      = 8,
  parameter int unsigned DATA_BYTES = 4
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [7:0]  addr_i,
  input  logic        we_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o,
  output logic        sclk_o,
  output logic        cs_n_o,
  output logic        mosi_o,
  input  logic        miso_i
);
  logic [7:0]       op;
  logic [2:0]       len;
  logic             rd, go_req, busy, active, tick;
  logic [31:0]      xaddr, txd, rx;
  cfg_t             cfg;
  logic [DIV_W-1:0] div;

  spi_fm_regs #(.DIV_W(DIV_W)) i_regs (
    .clk_i, .rst_ni, .addr_i, .we_i, .wdata_i, .rdata_o,
    .busy_i(busy), .rx_i(rx), .op_o(op), .len_o(len), .rd_o(rd),
    .addr_o(xaddr), .txd_o(txd), .cfg_o(cfg), .div_o(div), .go_o(go_req)
  );

  spi_fm_clkgen #(.DIV_W(DIV_W)) i_clkgen (
    .clk_i, .rst_ni, .active_i(active), .div_i(div), .tick_o(tick)
  );

  spi_fm_engine #(.DATA_BYTES(DATA_BYTES)) i_engine (
    .clk_i, .rst_ni, .go_i(go_req), .tick_i(tick), .op_i(op), .len_i(len),
    .rd_i(rd), .addr_i(xaddr), .txd_i(txd), .cfg_i(cfg), .miso_i,
    .sclk_o, .cs_n_o, .mosi_o, .busy_o(busy), .active_o(active), .rx_o(rx)
  );
endmodule

// File: rtl/spi_fm_chk.sv
module spi_fm_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [7:0]  addr_i,
  input logic [31:0] rdata_o,
  input logic        sclk_o,
  input logic        cs_n_o,
  input logic        mosi_o,
  input logic        busy,
  input logic        go_req
);
  // R9
  sclk_in_frame_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_o |-> !cs_n_o);
  // R9
  mosi_hold_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sclk_o) |-> $stable(mosi_o));
  // R3
  drop_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && go_req) |=> ($stable(mosi_o) || $fell(sclk_o)));
  // R11
  cs_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cs_n_o) |-> (!busy && !sclk_o && $past(!sclk_o)));
  // R2
  stat_unused_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == 8'h00) |-> (rdata_o[31:1] == 31'd0));
endmodule

bind spi_flash_master spi_fm_chk i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .rdata_o(rdata_o),
  .sclk_o(sclk_o), .cs_n_o(cs_n_o), .mosi_o(mosi_o), .busy(busy), .go_req(go_req)
);

// File: tb/test_spi_flash_master.sv
`timescale 1ns/1ps
module test_spi_flash_master;
  logic        clk = 1'b0, rst_n = 1'b0, we = 1'b0, miso = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic        sclk, cs_n, mosi;

  int n_chk = 0, n_fail = 0, frames_seen = 0, frames_exp = 0;
  bit armed = 1'b0, late = 1'b0;

  typedef struct packed {
    int          nbytes;
    logic [79:0] frame;
    int          half;
  } exp_t;
  exp_t exp_q[$];

  always #10 clk = ~clk;

  spi_flash_master i_spi_flash_master (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .we_i(we), .wdata_i(wdata),
    .rdata_o(rdata), .sclk_o(sclk), .cs_n_o(cs_n), .mosi_o(mosi), .miso_i(miso)
  );

  task automatic chk(input bit ok, input string tag, input logic [79:0] act, input logic [79:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] resp(input int k);
    return 8'hC3 ^ 8'(k * 37);
  endfunction

  function automatic logic sbit(input int j);
    logic [7:0] b;
    b = resp(j / 8);
    return b[7 - (j % 8)];
  endfunction

  // flash model
  int          nb = 0;
  logic [79:0] obs = '0;
  realtime     t_cs = 0, t_rise1 = 0, t_fall = 0;
  bit          first_rise = 1'b0;

  always @(negedge cs_n) begin
    nb = 0; obs = '0; t_cs = $realtime; first_rise = 1'b1;
    if (!late) #2 miso = sbit(0);
  end
  always @(posedge sclk) if (!cs_n) begin
    obs = {obs[78:0], mosi};
    if (first_rise) begin t_rise1 = $realtime; first_rise = 1'b0; end
    nb++;
    if (late) #2 miso = sbit(nb - 1);
  end
  always @(negedge sclk) if (!cs_n) begin
    t_fall = $realtime;
    if (!late) #2 miso = sbit(nb);
  end

  // monitor: pop expected frame and compare
  always @(posedge cs_n) if (armed) begin
    exp_t e;
    frames_seen++;
    if (exp_q.size() == 0) begin
      chk(1'b0, "R3 unexpected frame", 80'(frames_seen), 80'(frames_exp));
    end else begin
      e = exp_q.pop_front();
      chk(nb == e.nbytes * 8, "R5 R6 R7 bit count", 80'(nb), 80'(e.nbytes * 8));
      chk((obs << (80 - nb)) == e.frame, "R4 mosi frame", obs << (80 - nb), e.frame);
      chk(int'(t_rise1 - t_cs) == e.half, "R11 cs setup", 80'(int'(t_rise1 - t_cs)), 80'(e.half));
      chk(int'($realtime - t_fall) == e.half, "R11 cs hold", 80'(int'($realtime - t_fall)), 80'(e.half));
    end
  end

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic xfer(input logic [7:0] op, input bit rd, input int len, input logic [31:0] ad,
                      input logic [31:0] tx, input bit a4, input bit envdis, input bit cap,
                      input int dv, input bit lt, input bit poke, input string tag);
    int na, dm, n, k, el;
    logic [79:0] f;
    logic [31:0] r, v;
    exp_t e;
    el = (len > 4) ? 4 : len;
    na = a4 ? 4 : 3;
    dm = (rd && !envdis && el > 0) ? 1 : 0;
    n  = 1 + na + dm + el;
    f = '0; k = 0;
    f[79 -: 8] = op; k++;
    for (int i = na - 1; i >= 0; i--) begin f[79 - 8 * k -: 8] = ad[8 * i +: 8]; k++; end
    if (dm == 1) k++;
    for (int i = el - 1; i >= 0; i--) begin
      f[79 - 8 * k -: 8] = rd ? 8'h00 : tx[8 * i +: 8]; k++;
    end
    r = '0;
    if (rd) for (int i = 0; i < el; i++) r = {r[23:0], resp(1 + na + dm + i)};
    e.nbytes = n; e.frame = f; e.half = (dv + 1) * 20;
    exp_q.push_back(e);
    frames_exp++;
    late = lt;
    bus_wr(8'h10, (32'(a4) << 12) | (32'(envdis) << 11) | (32'(cap) << 10));
    bus_wr(8'h14, 32'(dv));
    bus_wr(8'h08, ad);
    bus_wr(8'h0C, tx);
    bus_wr(8'h04, (32'(rd) << 16) | (32'(len) << 8) | 32'(op));
    bus_wr(8'h1C, 32'h1);
    if (poke) begin
      repeat (10) @(negedge clk);
      bus_rd(8'h00, v);
      chk(v == 32'h1, "R2 busy during transfer", 80'(v), 80'h1);
      bus_wr(8'h04, 32'h0001_04EB);
      bus_wr(8'h1C, 32'h1);
    end
    do bus_rd(8'h00, v); while (v[0]);
    bus_rd(8'h18, v);
    chk(v == r, tag, 80'(v), 80'(r));
    chk(!sclk && cs_n, "R9 idle clock low", 80'({sclk, cs_n}), 80'b01);
  endtask

  initial begin
    #(20 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    armed = 1'b1;
    // R1
    bus_rd(8'h00, v); chk(v == 0, "R1 status reset", 80'(v), 80'h0);
    bus_rd(8'h10, v); chk(v == 0, "R1 config reset", 80'(v), 80'h0);
    chk(cs_n && !sclk && !mosi, "R1 pins reset", 80'({cs_n, sclk, mosi}), 80'b100);
    // R2 unused bits
    bus_wr(8'h10, 32'hFFFF_FFFF);
    bus_rd(8'h10, v); chk(v == 32'h0000_1C00, "R2 config bits", 80'(v), 80'h1C00);
    bus_wr(8'h10, 32'h0);
    // R5 three-byte read
    xfer(8'h03, 1, 4, 32'h1234_5678, 32'h0, 0, 1, 0, 0, 0, 0, "R8 R5 read 3-byte addr");
    // R5 four-byte read
    xfer(8'h13, 1, 2, 32'h89AB_CDEF, 32'h0, 1, 1, 0, 1, 0, 0, "R8 R5 read 4-byte addr");
    // R3 R7 write with second start during frame
    xfer(8'h02, 0, 3, 32'h0000_4321, 32'hAABB_CCDD, 0, 1, 0, 2, 0, 1, "R3 R7 write rx zero");
    // R6 envelope enabled
    xfer(8'h0B, 1, 1, 32'h0102_0304, 32'h0, 1, 0, 0, 0, 0, 0, "R6 read after pre-data byte");
    // R10 late-presenting device with delayed capture
    xfer(8'h03, 1, 4, 32'h00AB_CDEF, 32'h0, 0, 1, 1, 1, 1, 0, "R10 delayed capture");
    late = 1'b0;
    // R6 no data: no pre-data byte
    xfer(8'h05, 1, 0, 32'h0, 32'h0, 0, 0, 0, 0, 0, 0, "R6 R8 zero-length read");
    // R7 length clamp
    xfer(8'h32, 0, 7, 32'h0011_2233, 32'h5566_7788, 1, 1, 0, 0, 0, 0, "R7 clamped write");
    repeat (20) @(negedge clk);
    chk(frames_seen == frames_exp, "R3 frame count", 80'(frames_seen), 80'(frames_exp));
    chk(exp_q.size() == 0, "R3 scoreboard drained", 80'(exp_q.size()), 80'h0);
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule